// File: doc/BRIEF.md
# Dual-Register Input Capture Timer

This block is one timer channel set up for measuring when things happen on a capture input. A counter advances once per clock while counting is allowed. Selected edges of the capture input copy the counter into capture register A and then into capture register B, always in that order. The gap between the two loads gives a pulse width or a period without any software timing.

A trigger restarts the counter from zero and prepares register A to take the next load. The trigger can come from a programmable edge of either the capture input or an auxiliary input. It can also come from the counter matching a compare register C. After register B has been loaded, the counter can be halted in one of two ways. A stop ends at the next trigger. A disable lasts until software writes an enable command.

Sticky status flags record overflow, each load, a load that overran an unread flag, a compare match and an external trigger. Reading the status clears them. Everything is accessed through a small register port with an address, write and read strobes, and a combinational read bus. Both pins pass through a two-flop synchroniser before edge detection, so every capture and trigger happens a fixed number of cycles after the pin changes.

Top module: `capture_timer`

## Requirements
- R1: After synchronous reset the counter, both capture registers, compare register C, the mode register and all status flags are zero, and the counter is not counting.
- R2: Writing register address 0 with bit 0 set enables counting, and writing it with bit 1 set disables counting; disable wins when both bits are set. While counting is enabled the counter rises by one each clock, and while it is disabled the counter holds its value.
- R3: Mode bits [1:0] select the edge that loads register A: 0 none, 1 rising, 2 falling, 3 either. When the capture input changes during a cycle in which the counter reads v, and the counter is running, register A receives v+2.
- R4: Mode bits [3:2] select the edge that loads register B, with the same encoding, from the same capture input. Register B loads only after register A has loaded since the last trigger or B load, and register A loads again only after register B has loaded.
- R5: When mode bit 4 is set, a load of register B stops the counter. The next trigger restarts counting from zero.
- R6: When mode bit 5 is set, a load of register B disables counting. A trigger then resets the counter to zero but does not resume counting; only an enable command does.
- R7: Mode bits [7:6] select the trigger edge (0 none, 1 rising, 2 falling, 3 either). Mode bit 8 selects the trigger pin: 0 is the capture input, 1 is the auxiliary input. After a trigger edge the counter reads 0 three cycles after the pin change, and counting resumes from there if it is enabled. A trigger makes register A the next to load. It also sets status bit 5.
- R8: Register address 5 holds compare value C. A match between the running counter and C sets status bit 4. If mode bit 9 is also set, the match restarts the counter, so the count runs 0..C.
- R9: A running counter at its all-ones value wraps to 0 on the next clock and sets status bit 0.
- R10: Status bit 1 (overrun) is set when register A or B loads while its own loaded flag (status bit 2 or bit 3) is still set.
- R11: Status (address 6) bits 0..5 are sticky and clear when a read strobe is given at that address. Bit 6 shows live whether the counter is running.
- R12: The register map is as follows. Address 1 is the mode register, readable and writable. Address 2 reads the counter, address 3 reads register A, and address 4 reads register B. Address 5 holds C, readable and writable. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| cap_in | input | 1 | Capture input, asynchronous |
| aux_in | input | 1 | Auxiliary trigger input, asynchronous |

## Verification
The capture path is driven with rising-only, falling-only, either-edge and disabled edge selections, including cases where A and B share an edge. These cases separate a correct A-then-B order from one where B can load first or A can reload without B. Triggers are applied from each pin with different edge polarities, and with the opposite pin toggling, to confirm that only the selected source restarts the count. The stop and disable halts are each followed by a trigger. The two must differ: a trigger resumes counting after a stop but only zeroes the counter after a disable. Compare restart, wrap-around and overrun are each provoked at their exact cycle, to separate a restart from a wrap and an overrun from an ordinary reload.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Mode register; a_edge occupies the least significant bits.
    typedef struct packed {
        logic [5:0] spare;
        logic       cmp_restart;
        logic       trig_from_aux;
        edge_sel_e  trig_edge;
        logic       off_on_b;
        logic       stop_on_b;
        edge_sel_e  b_edge;
        edge_sel_e  a_edge;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [2:0] {
        ADDR_CMD   = 3'd0,
        ADDR_MODE  = 3'd1,
        ADDR_COUNT = 3'd2,
        ADDR_CAPA  = 3'd3,
        ADDR_CAPB  = 3'd4,
        ADDR_CMPC  = 3'd5,
        ADDR_STAT  = 3'd6,
        ADDR_NONE  = 3'd7
    } reg_addr_e;

    // Status view; overflow is bit 0, counting is bit 6.
    typedef struct packed {
        logic counting;
        logic ext_trig;
        logic cmp_hit;
        logic b_loaded;
        logic a_loaded;
        logic overrun;
        logic overflow;
    } status_t;

    localparam int CMD_ENABLE_BIT  = 0;
    localparam int CMD_DISABLE_BIT = 1;

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int STAGES = 3;

    for (genvar gi = 0; gi < N; gi++) begin : g_pin
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], din[gi]};
        end

        // pipe[1] is the synchronised level, pipe[2] its previous value.
        assign rise[gi] =  pipe[1] & ~pipe[2];
        assign fall[gi] = ~pipe[1] &  pipe[2];
    end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             stop_req,
    input  logic             off_req,
    input  logic             ext_trig,
    input  logic             cmp_restart,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             cmp_match,
    output logic             restart,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic enabled_q;
    logic stopped_q;

    assign active    = enabled_q & ~stopped_q;
    assign cmp_match = active && (cnt == cmp_val);
    assign restart   = ext_trig | (cmp_match & cmp_restart);
    assign ovf_evt   = active && (&cnt) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled_q <= 1'b0;
            stopped_q <= 1'b0;
            cnt       <= '0;
        end else begin
            if (stop_req) stopped_q <= 1'b1;
            if (off_req)  enabled_q <= 1'b0;
            if (ext_trig) stopped_q <= 1'b0;
            if (en_cmd) begin
                enabled_q <= 1'b1;
                stopped_q <= 1'b0;
            end
            if (dis_cmd)  enabled_q <= 1'b0;

            if (restart)     cnt <= '0;
            else if (active) cnt <= cnt + ONE;
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        active && !restart |=> cnt == $past(cnt) + ONE);

    assert_disable_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        dis_cmd |=> !active);

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> cnt == '0);
endmodule

// File: rtl/ct_capture.sv
module ct_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             a_hit,
    input  logic             b_hit,
    input  logic             rearm,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             ld_a,
    output logic             ld_b
);
    logic expect_a_q;

    assign ld_a =  expect_a_q & a_hit;
    assign ld_b = ~expect_a_q & b_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_a_q <= 1'b1;
            cap_a      <= '0;
            cap_b      <= '0;
        end else begin
            if (rearm)     expect_a_q <= 1'b1;
            else if (ld_a) expect_a_q <= 1'b0;
            else if (ld_b) expect_a_q <= 1'b1;
            if (ld_a) cap_a <= cnt;
            if (ld_b) cap_b <= cnt;
        end
    end

    assert_capture_value_R3: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> cap_a == $past(cnt));

    assert_a_not_twice_R4: assert property (@(posedge clk) disable iff (rst)
        ld_a && !rearm |=> !ld_a);

    assert_b_not_twice_R4: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> !ld_b);
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cap_in,
    input  logic              aux_in
);
    localparam int SRC_CAP = 0;
    localparam int SRC_AUX = 1;
    localparam int N_PINS  = 2;

    reg_addr_e addr;
    assign addr = reg_addr_e'(reg_addr);

    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_q;
    status_t          flag_q;
    status_t          evt;
    status_t          stat_view;

    logic [N_PINS-1:0] rise, fall;
    logic              trig_rise, trig_fall, ext_trig;
    logic              en_cmd, dis_cmd, stat_clr;
    logic              a_hit, b_hit, ld_a, ld_b;
    logic [CNT_W-1:0]  cnt, cap_a, cap_b;
    logic              active, cmp_match, restart, ovf_evt;

    ct_sync_edge #(.N(N_PINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({aux_in, cap_in}),
        .rise (rise),
        .fall (fall)
    );

    assign trig_rise = mode_q.trig_from_aux ? rise[SRC_AUX] : rise[SRC_CAP];
    assign trig_fall = mode_q.trig_from_aux ? fall[SRC_AUX] : fall[SRC_CAP];
    assign ext_trig  = edge_hit(mode_q.trig_edge, trig_rise, trig_fall);
    assign a_hit     = edge_hit(mode_q.a_edge, rise[SRC_CAP], fall[SRC_CAP]);
    assign b_hit     = edge_hit(mode_q.b_edge, rise[SRC_CAP], fall[SRC_CAP]);

    assign en_cmd   = reg_wr && (addr == ADDR_CMD) && reg_wdata[CMD_ENABLE_BIT];
    assign dis_cmd  = reg_wr && (addr == ADDR_CMD) && reg_wdata[CMD_DISABLE_BIT];
    assign stat_clr = reg_rd && (addr == ADDR_STAT);

    ct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .en_cmd      (en_cmd),
        .dis_cmd     (dis_cmd),
        .stop_req    (ld_b & mode_q.stop_on_b),
        .off_req     (ld_b & mode_q.off_on_b),
        .ext_trig    (ext_trig),
        .cmp_restart (mode_q.cmp_restart),
        .cmp_val     (cmp_q),
        .cnt         (cnt),
        .active      (active),
        .cmp_match   (cmp_match),
        .restart     (restart),
        .ovf_evt     (ovf_evt)
    );

    ct_capture #(.CNT_W(CNT_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .cnt   (cnt),
        .a_hit (a_hit),
        .b_hit (b_hit),
        .rearm (restart),
        .cap_a (cap_a),
        .cap_b (cap_b),
        .ld_a  (ld_a),
        .ld_b  (ld_b)
    );

    always_comb begin
        evt          = '0;
        evt.overflow = ovf_evt;
        evt.overrun  = !stat_clr && ((ld_a && flag_q.a_loaded) || (ld_b && flag_q.b_loaded));
        evt.a_loaded = ld_a;
        evt.b_loaded = ld_b;
        evt.cmp_hit  = cmp_match;
        evt.ext_trig = ext_trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cmp_q  <= '0;
            flag_q <= '0;
        end else begin
            if (reg_wr && addr == ADDR_MODE) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
            if (reg_wr && addr == ADDR_CMPC) cmp_q  <= reg_wdata[CNT_W-1:0];
            flag_q <= (stat_clr ? status_t'('0) : flag_q) | evt;
        end
    end

    always_comb begin
        stat_view          = flag_q;
        stat_view.counting = active;
    end

    always_comb begin
        case (addr)
            ADDR_MODE:  reg_rdata = DATA_W'(mode_q);
            ADDR_COUNT: reg_rdata = DATA_W'(cnt);
            ADDR_CAPA:  reg_rdata = DATA_W'(cap_a);
            ADDR_CAPB:  reg_rdata = DATA_W'(cap_b);
            ADDR_CMPC:  reg_rdata = DATA_W'(cmp_q);
            ADDR_STAT:  reg_rdata = DATA_W'(stat_view);
            default:    reg_rdata = '0;
        endcase
    end

    assert_stop_after_b_R5: assert property (@(posedge clk) disable iff (rst)
        ld_b && mode_q.stop_on_b && !ext_trig && !en_cmd |=> !active);

    assert_off_after_b_R6: assert property (@(posedge clk) disable iff (rst)
        ld_b && mode_q.off_on_b && !en_cmd |=> !active);

    assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
        ld_a && flag_q.a_loaded && !stat_clr |=> flag_q.overrun);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        flag_q.a_loaded && !stat_clr |=> flag_q.a_loaded);

    assert_load_flag_R3: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> flag_q.a_loaded);
endmodule

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int DW = 16;

    localparam logic [2:0] A_CMD = 3'd0, A_MODE = 3'd1, A_CNT = 3'd2, A_RA = 3'd3,
                           A_RB = 3'd4, A_RC = 3'd5, A_ST = 3'd6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cap_in = 1'b0;
    logic          aux_in = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    capture_timer #(.CNT_W(CW), .DATA_W(DW)) u_capture_timer (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .cap_in, .aux_in
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_clear();
        reg_addr = A_ST;
        reg_rd   = 1'b1;
        tick(1);
        reg_rd   = 1'b0;
    endtask

    function automatic logic [15:0] mk_mode(logic [1:0] a, logic [1:0] b, logic stp, logic off,
                                            logic [1:0] te, logic src, logic cpc);
        return {6'b0, cpc, src, te, off, stp, b, a};
    endfunction

    function automatic logic [15:0] m8(logic [15:0] v);
        return v & 16'h00FF;
    endfunction

    // Changes cap_in, returns the counter value seen in that cycle, waits three cycles.
    task automatic edge_cap(input logic v, output logic [15:0] v0);
        peek(A_CNT, v0);
        cap_in = v;
        tick(3);
    endtask

    // Rising pulse on aux_in; counter sampled three and four cycles after the change.
    task automatic trig_aux(output logic [15:0] v3, output logic [15:0] v4);
        aux_in = 1'b1;
        tick(3);
        peek(A_CNT, v3);
        tick(1);
        peek(A_CNT, v4);
        aux_in = 1'b0;
        tick(3);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(A_CNT, v);  chk("R1", "counter after reset", v, 16'h0);
        peek(A_ST, v);   chk("R1", "status after reset", v, 16'h0);
        peek(A_RA, v);   chk("R1", "capture A after reset", v, 16'h0);
        peek(A_MODE, v); chk("R1", "mode after reset", v, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(A_RC, 16'h005A);
        peek(A_RC, v); chk("R12", "C readback", v, 16'h005A);
        wr(A_MODE, 16'h02C6);
        peek(A_MODE, v); chk("R12", "mode readback", v, 16'h02C6);
        peek(3'd7, v); chk("R12", "unused address", v, 16'h0);
        wr(A_MODE, 16'h0);
        wr(A_RC, 16'h0);
    endtask

    task automatic t_count();
        logic [15:0] v, w;
        wr(A_CMD, 16'h0001);
        peek(A_CNT, v); tick(4); peek(A_CNT, w);
        chk("R2", "counts when enabled", w, m8(v + 4));
        wr(A_CMD, 16'h0003);
        peek(A_CNT, v); tick(4); peek(A_CNT, w);
        chk("R2", "disable wins and holds", w, v);
        wr(A_CMD, 16'h0001);
        peek(A_CNT, v); tick(2); peek(A_CNT, w);
        chk("R2", "re-enabled counting", w, m8(v + 2));
    endtask

    task automatic t_trigger();
        logic [15:0] v3, v4, v0, w;
        wr(A_MODE, mk_mode(2'd0, 2'd0, 0, 0, 2'd1, 1'b1, 0));
        rd_clear();
        trig_aux(v3, v4);
        chk("R7", "aux rise zeroes counter", v3, 16'h0);
        chk("R7", "counting resumes after trigger", v4, 16'h1);
        peek(A_ST, w);
        chk("R7", "trigger status bit5", w & 16'h0020, 16'h0020);
        edge_cap(1'b1, v0); peek(A_CNT, w);
        chk("R7", "cap_in ignored when aux selected", w, m8(v0 + 3));
        wr(A_MODE, mk_mode(2'd0, 2'd0, 0, 0, 2'd2, 1'b0, 0));
        edge_cap(1'b0, v0); peek(A_CNT, w);
        chk("R7", "cap_in fall trigger zeroes counter", w, 16'h0);
    endtask

    task automatic t_capture();
        logic [15:0] v3, v4, v0, w;
        wr(A_MODE, mk_mode(2'd1, 2'd2, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        rd_clear();
        edge_cap(1'b1, v0); peek(A_RA, w);
        chk("R3", "A loads on rise with v+2", w, m8(v0 + 2));
        peek(A_ST, w);
        chk("R3", "A loaded status bit2", w & 16'h000C, 16'h0004);
        edge_cap(1'b0, v0); peek(A_RB, w);
        chk("R4", "B loads on fall with v+2", w, m8(v0 + 2));
    endtask

    task automatic t_order();
        logic [15:0] v3, v4, v0, w, rb_old;
        wr(A_MODE, mk_mode(2'd2, 2'd1, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        peek(A_RB, rb_old);
        edge_cap(1'b1, v0); peek(A_RB, w);
        chk("R4", "B ignores edge before A", w, rb_old);
        edge_cap(1'b0, v0); peek(A_RA, w);
        chk("R3", "A loads on fall", w, m8(v0 + 2));
        edge_cap(1'b1, v0); peek(A_RB, w);
        chk("R4", "B loads after A", w, m8(v0 + 2));
        edge_cap(1'b0, v0);
    endtask

    task automatic t_none_both();
        logic [15:0] v3, v4, v0, w, ra_old, rb_old;
        wr(A_MODE, mk_mode(2'd0, 2'd3, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        peek(A_RA, ra_old); peek(A_RB, rb_old);
        edge_cap(1'b1, v0); edge_cap(1'b0, v0);
        peek(A_RA, w); chk("R3", "A select none never loads", w, ra_old);
        peek(A_RB, w); chk("R4", "B waits for A forever", w, rb_old);
        wr(A_MODE, mk_mode(2'd3, 2'd3, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        edge_cap(1'b1, v0); peek(A_RA, w);
        chk("R3", "A on either edge", w, m8(v0 + 2));
        edge_cap(1'b0, v0); peek(A_RB, w);
        chk("R4", "B on either edge after A", w, m8(v0 + 2));
    endtask

    task automatic t_rearm();
        logic [15:0] v3, v4, v0, w, rb_old;
        wr(A_MODE, mk_mode(2'd1, 2'd1, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        edge_cap(1'b1, v0);
        edge_cap(1'b0, v0);
        trig_aux(v3, v4);
        peek(A_RB, rb_old);
        edge_cap(1'b1, v0); peek(A_RA, w);
        chk("R7", "trigger re-arms A", w, m8(v0 + 2));
        peek(A_RB, w);
        chk("R7", "B untouched after re-arm", w, rb_old);
        edge_cap(1'b0, v0);
    endtask

    task automatic t_stop();
        logic [15:0] v3, v4, v0, w, f;
        wr(A_MODE, mk_mode(2'd1, 2'd2, 1, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        edge_cap(1'b1, v0);
        edge_cap(1'b0, v0);
        peek(A_RB, w); chk("R5", "B value at stop", w, m8(v0 + 2));
        peek(A_CNT, f); chk("R5", "counter halted after B", f, m8(v0 + 3));
        tick(4); peek(A_CNT, w); chk("R5", "counter stays stopped", w, f);
        peek(A_ST, w); chk("R5", "counting bit6 clear", w & 16'h0040, 16'h0);
        trig_aux(v3, v4);
        chk("R5", "trigger zeroes stopped counter", v3, 16'h0);
        chk("R5", "trigger resumes stopped counter", v4, 16'h1);
    endtask

    task automatic t_off();
        logic [15:0] v3, v4, v0, w, f;
        wr(A_MODE, mk_mode(2'd1, 2'd2, 0, 1, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        edge_cap(1'b1, v0);
        edge_cap(1'b0, v0);
        peek(A_CNT, f); chk("R6", "counter disabled after B", f, m8(v0 + 3));
        tick(3); peek(A_CNT, w); chk("R6", "counter stays disabled", w, f);
        trig_aux(v3, v4);
        chk("R6", "trigger zeroes disabled counter", v3, 16'h0);
        chk("R6", "trigger does not resume", v4, 16'h0);
        wr(A_CMD, 16'h0001);
        peek(A_CNT, v0); tick(2); peek(A_CNT, w);
        chk("R6", "enable command resumes", w, m8(v0 + 2));
    endtask

    task automatic t_cmp();
        logic [15:0] v3, v4, w;
        wr(A_RC, 16'h0005);
        wr(A_MODE, mk_mode(2'd0, 2'd0, 0, 0, 2'd1, 1'b1, 1));
        rd_clear();
        trig_aux(v3, v4);
        peek(A_CNT, w); chk("R8", "count before match", w, 16'h4);
        tick(1); peek(A_CNT, w); chk("R8", "count reaches C", w, 16'h5);
        tick(1); peek(A_CNT, w); chk("R8", "restart after C", w, 16'h0);
        peek(A_ST, w); chk("R8", "compare status bit4", w & 16'h0010, 16'h0010);
        wr(A_MODE, mk_mode(2'd0, 2'd0, 0, 0, 2'd1, 1'b1, 0));
        rd_clear();
        trig_aux(v3, v4);
        tick(2); peek(A_CNT, w); chk("R8", "no restart when disabled bit9", w, 16'h6);
        peek(A_ST, w); chk("R8", "compare status without restart", w & 16'h0010, 16'h0010);
    endtask

    task automatic t_ovf();
        logic [15:0] v3, v4, w;
        rd_clear();
        trig_aux(v3, v4);
        tick(251); peek(A_CNT, w); chk("R9", "counter at all ones", w, 16'h00FF);
        peek(A_ST, w); chk("R9", "no overflow yet", w & 16'h0001, 16'h0);
        tick(1); peek(A_CNT, w); chk("R9", "wrap to zero", w, 16'h0);
        peek(A_ST, w); chk("R9", "overflow bit0", w & 16'h0001, 16'h0001);
    endtask

    task automatic t_overrun();
        logic [15:0] v3, v4, v0, w;
        wr(A_MODE, mk_mode(2'd1, 2'd2, 0, 0, 2'd1, 1'b1, 0));
        trig_aux(v3, v4);
        rd_clear();
        edge_cap(1'b1, v0);
        edge_cap(1'b0, v0);
        peek(A_ST, w); chk("R10", "no overrun on first loads", w & 16'h0002, 16'h0);
        edge_cap(1'b1, v0);
        peek(A_ST, w); chk("R10", "overrun on A reload", w & 16'h0002, 16'h0002);
        edge_cap(1'b0, v0);
        peek(A_ST, w); chk("R11", "flags sticky until read", w & 16'h000E, 16'h000E);
        wr(A_CMD, 16'h0002);
        rd_clear();
        peek(A_ST, w); chk("R11", "read clears status", w, 16'h0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_regmap();
        t_count();
        t_trigger();
        t_capture();
        t_order();
        t_none_both();
        t_rearm();
        t_stop();
        t_off();
        t_cmp();
        t_ovf();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule